// File: doc/BRIEF.md
# System Control Register Block

A small register block on a simple 32-bit memory-mapped bus. It holds a two-bit lamp register that drives an output pin, a scratch control register that reads back as written, and a switch-input location that always reads as zero. It also keeps two loadable timebase counters, one counting whole seconds and one counting hundredths of a second. Both are derived from a reference clock whose frequency is a parameter.

Three locations of the map belong to a separate prescaled-counter block. This block decodes them, forwards each access over a side port, and returns the side block's read value on the bus. Software loads either timebase by writing it, and counting resumes from the loaded value.

The address window is 4 KB. Only word-aligned addresses are decoded. Reads are registered: read data appears in the cycle after the read strobe.

Top module: `sysctl_regs`

## Requirements
- R1: Decoded word offsets are 0x000 (lamp), 0x008 (switches), 0x010 (seconds), 0x014 (hundredths), 0x018 (side counter), 0x01C (side reload), 0x020 (side current) and 0x04C (scratch). Any other offset, or any address with bits [1:0] not zero, reads as zero, and writing it changes nothing.
- R2: A write to the lamp offset stores bits [1:0] of the write data. `led_o` shows the stored value one cycle later. A read of the lamp offset returns those two bits with all upper bits zero.
- R3: The switch offset always reads zero, and writes to it are ignored.
- R4: The scratch offset is a full 32-bit register that reads back exactly the last value written.
- R5: `bus_rdata` is registered. It changes only at the clock edge that samples `bus_re`, and it holds its value between reads.
- R6: The seconds counter increments once every REF_HZ reference cycles.
- R7: The hundredths counter increments once every REF_HZ/100 reference cycles.
- R8: Writing a timebase offset loads that counter with the write data and clears its divider. The first increment after a load comes one full period after the write edge. Counters wrap from 0xFFFFFFFF to 0.
- R9: Reset clears the lamp register, the scratch register and both timebase counters to zero.
- R10: A write to a side offset asserts `ps_wr_en` in the same cycle, with `ps_wdata` equal to the bus write data. `ps_sel` is 0 for the counter offset (0x018), 1 for the reload offset (0x01C) and 2 for the current-count offset (0x020). No other write asserts `ps_wr_en`.
- R11: A read of a side offset asserts `ps_rd_en` in the same cycle, with `ps_sel` coded as in R10. The `ps_rdata` value present in that cycle is returned on `bus_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W | Registered read data |
| led_o | output | 2 | Lamp register contents |
| ps_wr_en | output | 1 | Write forwarded to the prescaled-counter block |
| ps_rd_en | output | 1 | Read forwarded to the prescaled-counter block |
| ps_sel | output | 2 | Side register select (0 counter, 1 reload, 2 current) |
| ps_wdata | output | DATA_W | Write data forwarded to the side block |
| ps_rdata | input | DATA_W | Read data from the side block |

## Verification
The assertions check the following on every cycle:
- the lamp register changes only after a lamp write, and takes the written low bits;
- switch and undecoded reads return zero;
- side reads return the side block's data one cycle later;
- scratch writes never leak onto the side port.

Timebase behaviour needs the bench's timed scenarios:
- the exact edge of the first increment after a load;
- the wrap at the top of the counter range;
- the return to zero under a reset in mid-run.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int ADDR_W = 12;

   localparam logic [ADDR_W-1:0] OFS_LAMP    = 12'h000;
   localparam logic [ADDR_W-1:0] OFS_KEYS    = 12'h008;
   localparam logic [ADDR_W-1:0] OFS_SEC     = 12'h010;
   localparam logic [ADDR_W-1:0] OFS_CENTI   = 12'h014;
   localparam logic [ADDR_W-1:0] OFS_PSCNT   = 12'h018;
   localparam logic [ADDR_W-1:0] OFS_PSLOAD  = 12'h01C;
   localparam logic [ADDR_W-1:0] OFS_PSCUR   = 12'h020;
   localparam logic [ADDR_W-1:0] OFS_SCRATCH = 12'h04C;

   localparam int NUM_TB = 2;

   typedef enum logic [1:0] {
      PS_COUNT = 2'd0,
      PS_LOAD  = 2'd1,
      PS_CUR   = 2'd2
   } ps_sel_e;

   typedef struct packed {
      logic lamp;
      logic keys;
      logic sec;
      logic centi;
      logic side;
      logic scratch;
   } hit_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   output hit_t              hit,
   output ps_sel_e           sel
);

   logic aligned;

   assign aligned = (addr[1:0] == 2'b00);

   always_comb begin
      hit         = '0;
      sel         = PS_COUNT;
      if (aligned) begin
         hit.lamp    = (addr == OFS_LAMP);
         hit.keys    = (addr == OFS_KEYS);
         hit.sec     = (addr == OFS_SEC);
         hit.centi   = (addr == OFS_CENTI);
         hit.scratch = (addr == OFS_SCRATCH);
         if (addr == OFS_PSCNT) begin
            hit.side = 1'b1;
            sel      = PS_COUNT;
         end else if (addr == OFS_PSLOAD) begin
            hit.side = 1'b1;
            sel      = PS_LOAD;
         end else if (addr == OFS_PSCUR) begin
            hit.side = 1'b1;
            sel      = PS_CUR;
         end
      end
   end

endmodule

// File: rtl/sysctl_divider.sv
module sysctl_divider #(
   parameter int unsigned DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);

   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("sysctl_divider: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || clr || tick) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/sysctl_timebase.sv
module sysctl_timebase #(
   parameter int DATA_W = 32,
   parameter int unsigned DIV = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   output logic [DATA_W-1:0] value
);

   logic tick;

   sysctl_divider #(.DIV(DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (load),
      .tick  (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)    value <= '0;
      else if (load) value <= load_val;
      else if (tick) value <= value + 1'b1;
   end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
   import sysctl_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int unsigned REF_HZ = 50_000_000,
   parameter int unsigned SLOW_HZ = 1,
   parameter int unsigned FAST_HZ = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [11:0]       bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [1:0]        led_o,
   output logic              ps_wr_en,
   output logic              ps_rd_en,
   output logic [1:0]        ps_sel,
   output logic [DATA_W-1:0] ps_wdata,
   input  logic [DATA_W-1:0] ps_rdata
);

   if (DATA_W < 2) begin : g_bad_width
      $error("sysctl_regs: DATA_W must be at least 2");
   end
   if (REF_HZ % SLOW_HZ != 0 || REF_HZ % FAST_HZ != 0) begin : g_bad_ref
      $error("sysctl_regs: REF_HZ must be a multiple of both tick rates");
   end

   hit_t              hit;
   ps_sel_e           sel;
   logic [1:0]        led_q;
   logic [DATA_W-1:0] misc_q;
   logic [DATA_W-1:0] rd_mux;
   logic [NUM_TB-1:0] tb_load;
   logic [DATA_W-1:0] tb_val [NUM_TB];

   sysctl_decode u_dec (
      .addr (bus_addr),
      .hit  (hit),
      .sel  (sel)
   );

   assign tb_load[0] = bus_we && hit.sec;
   assign tb_load[1] = bus_we && hit.centi;

   for (genvar g = 0; g < NUM_TB; g++) begin : g_tb
      localparam int unsigned RATE = (g == 0) ? SLOW_HZ : FAST_HZ;
      sysctl_timebase #(.DATA_W(DATA_W), .DIV(REF_HZ / RATE)) u_tb (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (tb_load[g]),
         .load_val (bus_wdata),
         .value    (tb_val[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         led_q  <= '0;
         misc_q <= '0;
      end else if (bus_we) begin
         if (hit.lamp)    led_q  <= bus_wdata[1:0];
         if (hit.scratch) misc_q <= bus_wdata;
      end
   end

   assign led_o    = led_q;
   assign ps_wr_en = bus_we && hit.side;
   assign ps_rd_en = bus_re && hit.side;
   assign ps_sel   = sel;
   assign ps_wdata = bus_wdata;

   always_comb begin
      rd_mux = '0;
      if (hit.lamp)         rd_mux[1:0] = led_q;
      else if (hit.keys)    rd_mux      = '0;
      else if (hit.sec)     rd_mux      = tb_val[0];
      else if (hit.centi)   rd_mux      = tb_val[1];
      else if (hit.side)    rd_mux      = ps_rdata;
      else if (hit.scratch) rd_mux      = misc_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_mux;
   end

endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [11:0]       bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_re,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [1:0]        led_o,
   input logic              ps_wr_en,
   input logic [DATA_W-1:0] ps_rdata
);

   logic known;
   assign known = (bus_addr[1:0] == 2'b00) &&
                  (bus_addr inside {12'h000, 12'h008, 12'h010, 12'h014,
                                    12'h018, 12'h01C, 12'h020, 12'h04C});

   AST_LAMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 12'h000) |=> (led_o == $past(bus_wdata[1:0]))); // R2
   AST_LAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == 12'h000) |=> $stable(led_o)); // R2
   AST_KEYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == 12'h008) |=> (bus_rdata == '0)); // R3
   AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !known) |=> (bus_rdata == '0)); // R1
   AST_SIDE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == 12'h018) |=> (bus_rdata == $past(ps_rdata))); // R11
   AST_SCRATCH_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 12'h04C) |-> !ps_wr_en); // R10
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> $stable(bus_rdata)); // R5

endmodule

bind sysctl_regs sysctl_regs_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;

   localparam int unsigned REF = 1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic [1:0]  led_o;
   logic        ps_wr_en, ps_rd_en;
   logic [1:0]  ps_sel;
   logic [31:0] ps_wdata, ps_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   assign ps_rdata = 32'h5A5A_0000 | {30'b0, ps_sel};

   sysctl_regs #(.DATA_W(32), .REF_HZ(REF)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .led_o(led_o), .ps_wr_en(ps_wr_en), .ps_rd_en(ps_rd_en),
      .ps_sel(ps_sel), .ps_wdata(ps_wdata), .ps_rdata(ps_rdata)
   );

   typedef struct packed {
      logic        we;
      logic [11:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 12'h000, 32'hFFFF_FFFF, 32'h0,         8'd2},  // R2
      '{1'b0, 12'h000, 32'h0,         32'h3,         8'd2},  // R2
      '{1'b1, 12'h04C, 32'hDEAD_BEEF, 32'h0,         8'd4},  // R4
      '{1'b0, 12'h04C, 32'h0,         32'hDEAD_BEEF, 8'd4},  // R4
      '{1'b1, 12'h008, 32'h1234_5678, 32'h0,         8'd3},  // R3
      '{1'b0, 12'h008, 32'h0,         32'h0,         8'd3},  // R3
      '{1'b0, 12'h004, 32'h0,         32'h0,         8'd1},  // R1
      '{1'b0, 12'h048, 32'h0,         32'h0,         8'd1},  // R1
      '{1'b0, 12'hFFC, 32'h0,         32'h0,         8'd1},  // R1
      '{1'b1, 12'h04D, 32'h0,         32'h0,         8'd1},  // R1
      '{1'b0, 12'h04C, 32'h0,         32'hDEAD_BEEF, 8'd1},  // R1
      '{1'b0, 12'h04F, 32'h0,         32'h0,         8'd1},  // R1
      '{1'b0, 12'h018, 32'h0,         32'h5A5A_0000, 8'd11}, // R11
      '{1'b0, 12'h01C, 32'h0,         32'h5A5A_0001, 8'd11}, // R11
      '{1'b0, 12'h020, 32'h0,         32'h5A5A_0002, 8'd11}, // R11
      '{1'b1, 12'h000, 32'h0000_0002, 32'h0,         8'd2},  // R2
      '{1'b0, 12'h000, 32'h0,         32'h2,         8'd2}   // R2
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state
      check("R9 led_o", {30'b0, led_o}, 32'h0);
      rd(12'h000, d); check("R9 lamp", d, 32'h0);
      rd(12'h04C, d); check("R9 scratch", d, 32'h0);
      rd(12'h010, d); check("R9 seconds", d, 32'h0);
      rd(12'h014, d); check("R9 hundredths", d, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
         else begin
            rd(VEC[i].addr, d);
            check($sformatf("R%0d table[%0d]", VEC[i].req, i), d, VEC[i].exp);
         end
      end
      check("R2 led_o", {30'b0, led_o}, 32'h2);

      // R5: rdata holds until the edge that samples the read
      bus_addr = 12'h04C; bus_re = 1'b1; #1;
      check("R5 before edge", bus_rdata, 32'h2);
      @(negedge clk); bus_re = 1'b0;
      check("R5 after edge", bus_rdata, 32'hDEAD_BEEF);

      // R10: side write forwarding
      bus_addr = 12'h01C; bus_wdata = 32'h0000_0007; bus_we = 1'b1; #1;
      check("R10 wr_en", {31'b0, ps_wr_en}, 32'h1);
      check("R10 sel", {30'b0, ps_sel}, 32'h1);
      check("R10 wdata", ps_wdata, 32'h7);
      @(negedge clk); bus_we = 1'b0;
      bus_addr = 12'h04C; bus_wdata = 32'h1; bus_we = 1'b1; #1;
      check("R10 scratch no fwd", {31'b0, ps_wr_en}, 32'h0);
      @(negedge clk); bus_we = 1'b0;
      rd(12'h04C, d); check("R4 scratch rewrite", d, 32'h1);

      // R11: side read strobe
      bus_addr = 12'h020; bus_re = 1'b1; #1;
      check("R11 rd_en", {31'b0, ps_rd_en}, 32'h1);
      check("R11 sel", {30'b0, ps_sel}, 32'h2);
      @(negedge clk); bus_re = 1'b0;

      // R7 R8: hundredths load, first increment one full period later
      wr(12'h014, 32'd5);
      repeat (9) @(negedge clk);
      rd(12'h014, d); check("R8 hundredths before tick", d, 32'd5);
      rd(12'h014, d); check("R7 hundredths after tick", d, 32'd6);

      // R6 R8: seconds load and wrap
      wr(12'h010, 32'hFFFF_FFFF);
      repeat (999) @(negedge clk);
      rd(12'h010, d); check("R6 seconds before tick", d, 32'hFFFF_FFFF);
      rd(12'h010, d); check("R8 seconds wrap", d, 32'h0);

      // R9: reset in mid-run
      wr(12'h000, 32'h3);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check("R9 led_o again", {30'b0, led_o}, 32'h0);
      rd(12'h04C, d); check("R9 scratch again", d, 32'h0);
      rd(12'h014, d); check("R9 hundredths again", d, 32'h0);
      rd(12'h010, d); check("R9 seconds again", d, 32'h0);

      finish_run();
   end

endmodule